// File: doc/BRIEF.md
# Fuse Word Auto-Read Controller

The block sits between a 32-bit register bus and a one-time-programmable fuse array of 512 bytes. Software reads the array one word at a time. It writes a word address into the control word, then copies it into the internal read pointer by writing the address-set bit as 1. It then writes the read-start bit as 1. From the next cycle the block shows a busy flag, holds the fuse port on the latched word for a fixed number of cycles, and loads the fetched word into a read-only data register. Busy clears on the same clock edge that loads the data register.

A parameter sets the word size to 1 byte (512 words) or 4 bytes (128 words of 32 bits). Byte words are zero-extended in the data register. The array power-down bit resets to 1 and the auto-read enable bit resets to 0, and a start is honoured only while power-down is 0 and enable is 1. The fuse-programming field and the encrypt-enable bit are stored and read back but drive nothing.

Register map (byte offsets): control word at 0x04, data word at 0x08, auxiliary word at 0x10. Control word layout: bit 27 power-down, bit 26 busy (read-only), bit 25 read-start, bit 24 auto-read enable, bits 23:12 plain storage, bit 11 address-set, bits 10:0 word address, bits 31:28 read as 0. Auxiliary word: bit 10 encrypt-enable storage, all other bits read as 0. Register reads are registered: read data appears on the cycle after the read strobe and reflects state before that edge. Offsets not listed read as 0.

Top module: `fuse_autoread`

## Requirements
- R1: After reset the control word reads 0x0800_0000 (power-down set, all else 0), the data word reads 0 and the auxiliary word reads 0.
- R2: The read pointer takes the address field (bits 10:0) only on a control write with bit 11 = 1 while no read is in progress. A write with bit 11 = 0, or any control write during busy, leaves the pointer unchanged.
- R3: A control write with bit 25 = 1, bit 27 = 0 and bit 24 = 1 (values in that same write) while idle starts a read, and the register read in the very next cycle returns bit 26 = 1.
- R4: Busy stays 1 for exactly RD_LAT (default 8) cycles after the start write, and it falls on the same edge that loads the data register. A data read sampled on that edge still returns the old word.
- R5: Control writes during busy, including the ones that clear bits 25 and 11, neither cancel nor restart the read.
- R6: A start write with bit 27 = 1 or bit 24 = 0 is ignored. Busy stays 0 and the data word is unchanged.
- R7: The data word receives the fuse word at the latched pointer. With 1-byte words bits 31:8 read as 0.
- R8: A pointer at or beyond the array depth (128 words for 4-byte words, 512 for 1-byte words) loads 0 into the data word and issues no fuse request.
- R9: Control bits 31:28 and 26 are not writable. Bits 23:12 and auxiliary bit 10 read back as written and cause no action. Writes to the data word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 5 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data |
| fuseRdEn | output | 1 | Fuse request, high while a read of an in-range word is in progress |
| fuseAddr | output | log2(512/WORD_BYTES) | Fuse word address, held for the whole read |
| fuseData | input | 8*WORD_BYTES | Fuse word returned by the array |

## Verification
The bench goes after the start cycle. A design that set busy one edge late would return 0 on the first status read. One that cleared busy early, or loaded data before busy fell, would show a short busy run or the new word on the falling edge. A design that latched the address without the strobe, or during a read in progress, would fetch the wrong word. Clearing writes that killed the read would leave the data word stale. Starts with power-down set or enable clear must not raise busy. Addresses at and just past the array depth, checked for both word sizes, expose missing range checks and missing zero-extension.

// File: rtl/fuse_autoread_pkg.sv
package fuse_autoread_pkg;

  localparam int REG_AW = 5;
  localparam int REG_DW = 32;
  localparam int PTR_W  = 11;

  // register byte offsets
  localparam logic [REG_AW-1:0] OFF_CTRL = 5'h04;
  localparam logic [REG_AW-1:0] OFF_DATA = 5'h08;
  localparam logic [REG_AW-1:0] OFF_AUX  = 5'h10;

  // control word bit positions
  localparam int BIT_PD    = 27;
  localparam int BIT_BUSY  = 26;
  localparam int BIT_START = 25;
  localparam int BIT_EN    = 24;
  localparam int BIT_ASET  = 11;

  // writable bits: 27, 25, 24 and 23:0
  localparam logic [REG_DW-1:0] CTRL_WMASK = 32'h0BFF_FFFF;
  localparam logic [REG_DW-1:0] CTRL_RESET = 32'h0800_0000;
  localparam logic [REG_DW-1:0] AUX_WMASK  = 32'h0000_0400;

  typedef struct packed {
    logic busy;
    logic capture;
  } ctrlStrobes_t;

endpackage

// File: rtl/fuse_ar_ctrl.sv
module fuse_ar_ctrl
  import fuse_autoread_pkg::*;
#(
  parameter int RD_LAT = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = (RD_LAT > 2) ? $clog2(RD_LAT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RD_LAT - 1);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             launch;
  logic             capture;

  assign launch  = startReq && !busyQ;
  assign capture = busyQ && (cntQ == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (launch) begin
      busyQ <= 1'b1;
      cntQ  <= '0;
    end else if (capture) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (busyQ) begin
      cntQ  <= cntQ + CNT_W'(1);
    end
  end

  assign strobes.busy    = busyQ;
  assign strobes.capture = capture;

  // independent watch counter of the busy window
  logic [15:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else       busyLen <= busyQ ? busyLen + 16'd1 : 16'd0;
  end

  a_r3_launch_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> busyQ);

  a_r5_no_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !capture) |=> busyQ);

  a_r4_fall_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> !busyQ);

  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> (busyLen == 16'(RD_LAT)));

endmodule

// File: rtl/fuse_ar_dpath.sv
module fuse_ar_dpath
  import fuse_autoread_pkg::*;
#(
  parameter int WORD_BYTES  = 4,
  parameter int ARRAY_BYTES = 512
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      regWrEn,
  input  logic                                      regRdEn,
  input  logic [REG_AW-1:0]                         regAddr,
  input  logic [REG_DW-1:0]                         regWrData,
  output logic [REG_DW-1:0]                         regRdData,
  input  ctrlStrobes_t                              strobes,
  output logic                                      startReq,
  output logic                                      fuseRdEn,
  output logic [$clog2(ARRAY_BYTES/WORD_BYTES)-1:0] fuseAddr,
  input  logic [8*WORD_BYTES-1:0]                   fuseData
);

  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int DEPTH  = ARRAY_BYTES / WORD_BYTES;
  localparam int FA_W   = $clog2(DEPTH);

  logic [REG_DW-1:0] ctrlQ;
  logic [REG_DW-1:0] auxQ;
  logic [REG_DW-1:0] dataQ;
  logic [REG_DW-1:0] rdDataQ;
  logic [PTR_W-1:0]  readAddrQ;
  logic [REG_DW-1:0] fetched;
  logic [REG_DW-1:0] ctrlView;
  logic              wrCtrl;
  logic              wrAux;
  logic              inRange;

  assign wrCtrl = regWrEn && (regAddr == OFF_CTRL);
  assign wrAux  = regWrEn && (regAddr == OFF_AUX);

  // start is judged on the word being written
  assign startReq = wrCtrl && regWrData[BIT_START] &&
                    !regWrData[BIT_PD] && regWrData[BIT_EN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RESET;
      auxQ  <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= regWrData & CTRL_WMASK;
      if (wrAux)  auxQ  <= regWrData & AUX_WMASK;
    end
  end

  // read pointer: only on the strobe, frozen while a read runs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readAddrQ <= '0;
    end else if (wrCtrl && regWrData[BIT_ASET] && !strobes.busy) begin
      readAddrQ <= regWrData[PTR_W-1:0];
    end
  end

  assign inRange  = (32'(readAddrQ) < 32'(DEPTH));
  assign fuseAddr = readAddrQ[FA_W-1:0];
  assign fuseRdEn = strobes.busy && inRange;

  generate
    if (WORD_W >= REG_DW) begin : gWide
      assign fetched = fuseData[REG_DW-1:0];
    end else begin : gNarrow
      assign fetched = {{(REG_DW-WORD_W){1'b0}}, fuseData};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (strobes.capture) begin
      dataQ <= inRange ? fetched : '0;
    end
  end

  always_comb begin
    ctrlView           = ctrlQ;
    ctrlView[BIT_BUSY] = strobes.busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (regRdEn) begin
      case (regAddr)
        OFF_CTRL: rdDataQ <= ctrlView;
        OFF_DATA: rdDataQ <= dataQ;
        OFF_AUX:  rdDataQ <= auxQ;
        default:  rdDataQ <= '0;
      endcase
    end
  end

  assign regRdData = rdDataQ;

  a_r2_ptr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busy |=> $stable(readAddrQ));

  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && regWrData[BIT_START] && (regWrData[BIT_PD] || !regWrData[BIT_EN])
     && !strobes.busy) |=> !strobes.busy);

  a_r7_capture_word: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && inRange) |=> (dataQ == $past(fetched)));

  a_r8_range_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !inRange) |=> (dataQ == '0));

  a_r9_data_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == OFF_DATA) && !strobes.capture) |=> $stable(dataQ));

endmodule

// File: rtl/fuse_autoread.sv
module fuse_autoread
  import fuse_autoread_pkg::*;
#(
  parameter int WORD_BYTES  = 4,
  parameter int ARRAY_BYTES = 512,
  parameter int RD_LAT      = 8
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      regWrEn,
  input  logic                                      regRdEn,
  input  logic [REG_AW-1:0]                         regAddr,
  input  logic [REG_DW-1:0]                         regWrData,
  output logic [REG_DW-1:0]                         regRdData,
  output logic                                      fuseRdEn,
  output logic [$clog2(ARRAY_BYTES/WORD_BYTES)-1:0] fuseAddr,
  input  logic [8*WORD_BYTES-1:0]                   fuseData
);

  ctrlStrobes_t strobes;
  logic         startReq;

  fuse_ar_ctrl #(.RD_LAT(RD_LAT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strobes  (strobes)
  );

  fuse_ar_dpath #(.WORD_BYTES(WORD_BYTES), .ARRAY_BYTES(ARRAY_BYTES)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobes   (strobes),
    .startReq  (startReq),
    .fuseRdEn  (fuseRdEn),
    .fuseAddr  (fuseAddr),
    .fuseData  (fuseData)
  );

endmodule

// File: tb/fuse_autoread_tb_top.sv
`timescale 1ns/1ps
module fuse_autoread_tb_top;

  localparam int RD_LAT = 8;
  localparam logic [4:0] O_CTRL = 5'h04;
  localparam logic [4:0] O_DATA = 5'h08;
  localparam logic [4:0] O_AUX  = 5'h10;
  localparam logic [31:0] PD    = 32'h0800_0000;
  localparam logic [31:0] BUSY  = 32'h0400_0000;
  localparam logic [31:0] START = 32'h0200_0000;
  localparam logic [31:0] EN    = 32'h0100_0000;
  localparam logic [31:0] ASET  = 32'h0000_0800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdData32, rdData8;
  logic        fuseEn32, fuseEn8;
  logic [6:0]  fuseAddr32;
  logic [8:0]  fuseAddr8;
  logic [31:0] fuseData32;
  logic [7:0]  fuseData8;

  int checks = 0;
  int errors = 0;
  int curAddr = 0;
  logic [31:0] exp32 = '0;
  logic [31:0] exp8 = '0;

  always #10 clk = ~clk;

  function automatic logic [31:0] model32(input int a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [7:0] model8(input int a);
    logic [31:0] t;
    t = (32'(a) * 32'h0001_0193) + 32'h0000_0057;
    return t[7:0] ^ t[15:8];
  endfunction

  function automatic logic [31:0] want32(input int a);
    return (a < 128) ? model32(a) : 32'h0;
  endfunction

  function automatic logic [31:0] want8(input int a);
    return (a < 512) ? {24'h0, model8(a)} : 32'h0;
  endfunction

  assign fuseData32 = model32(int'(fuseAddr32));
  assign fuseData8  = model8(int'(fuseAddr8));

  fuse_autoread #(.WORD_BYTES(4), .RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rdData32),
    .fuseRdEn(fuseEn32), .fuseAddr(fuseAddr32), .fuseData(fuseData32)
  );

  fuse_autoread #(.WORD_BYTES(1), .RD_LAT(RD_LAT)) dut8_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rdData8),
    .fuseRdEn(fuseEn8), .fuseAddr(fuseAddr8), .fuseData(fuseData8)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] ofs, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = ofs; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] ofs, output logic [31:0] q32, output logic [31:0] q8);
    regRdEn = 1'b1; regAddr = ofs;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
    q32 = rdData32; q8 = rdData8;
  endtask

  // full software sequence: optional latch, start, clear, poll, fetch
  task automatic runRead(input int addr, input bit doLatch, input string tag);
    logic [31:0] a, b;
    int busyCnt;
    if (doLatch) begin
      busWrite(O_CTRL, EN | ASET | 32'(addr));
      busWrite(O_CTRL, EN | 32'(addr));
      curAddr = addr;
    end
    busWrite(O_CTRL, EN | START | 32'(addr));
    busRead(O_CTRL, a, b);
    check({tag, " R3 busy on first read (w32)"}, a & BUSY, BUSY);
    check({tag, " R3 busy on first read (w8)"}, b & BUSY, BUSY);
    busWrite(O_CTRL, EN | 32'(addr));
    busyCnt = 0;
    for (int i = 0; i < 20; i++) begin
      busRead(O_CTRL, a, b);
      if ((a & BUSY) == 0) break;
      busyCnt++;
    end
    check({tag, " R4/R5 busy polls after clear"}, 32'(busyCnt), 32'(RD_LAT - 2));
    check({tag, " R4 w8 busy low with w32"}, b & BUSY, 32'h0);
    busRead(O_DATA, a, b);
    exp32 = want32(curAddr);
    exp8  = want8(curAddr);
    check({tag, " R7/R8 data w32"}, a, exp32);
    check({tag, " R7/R8 data w8"}, b, exp8);
  endtask

  task automatic ignoredStart(input logic [31:0] w, input string tag);
    logic [31:0] a, b;
    busWrite(O_CTRL, w);
    busRead(O_CTRL, a, b);
    check({tag, " R6 busy stays 0 (w32)"}, a & BUSY, 32'h0);
    check({tag, " R6 busy stays 0 (w8)"}, b & BUSY, 32'h0);
    busRead(O_CTRL, a, b);
    check({tag, " R6 busy still 0"}, (a | b) & BUSY, 32'h0);
    busRead(O_DATA, a, b);
    check({tag, " R6 data unchanged w32"}, a, exp32);
    check({tag, " R6 data unchanged w8"}, b, exp8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd20240));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(O_CTRL, a, b);
    check("R1 ctrl reset w32", a, PD);
    check("R1 ctrl reset w8", b, PD);
    busRead(O_DATA, a, b);
    check("R1 data reset", a | b, 32'h0);
    busRead(O_AUX, a, b);
    check("R1 aux reset", a | b, 32'h0);

    // R9 storage and masking; power-down blocks the start in this write
    busWrite(O_CTRL, 32'hFFFF_FFFF);
    curAddr = 2047;
    busRead(O_CTRL, a, b);
    check("R9 ctrl readback mask", a, 32'h0BFF_FFFF);
    busWrite(O_CTRL, PD | 32'h00A5_C000);
    busRead(O_CTRL, a, b);
    check("R9 storage bits 23:12", b, PD | 32'h00A5_C000);
    busWrite(O_AUX, 32'hFFFF_FFFF);
    busRead(O_AUX, a, b);
    check("R9 aux only bit 10", a, 32'h0000_0400);
    busWrite(O_DATA, 32'hFFFF_FFFF);
    busRead(O_DATA, a, b);
    check("R9 data write ignored", a | b, 32'h0);

    // R8 pointer 2047 is out of range for both sizes
    runRead(2047, 1'b0, "oor2047");

    // R2 address field alone does not move the pointer
    runRead(3, 1'b1, "latch3");
    runRead(9, 1'b0, "nolatch9");

    // R8 boundaries
    runRead(127, 1'b1, "edge127");
    runRead(128, 1'b1, "edge128");
    runRead(511, 1'b1, "edge511");
    runRead(512, 1'b1, "edge512");

    // R4 exact window: busy falls on the edge that loads data
    runRead(10, 1'b1, "pre10");
    busWrite(O_CTRL, EN | ASET | 32'd20);
    busWrite(O_CTRL, EN | START | 32'd20);
    curAddr = 20;
    for (int i = 0; i < RD_LAT - 1; i++) begin
      busRead(O_CTRL, a, b);
      check("R4 busy inside window", (a & b) & BUSY, BUSY);
    end
    busRead(O_DATA, a, b);
    check("R4 old data on falling edge w32", a, exp32);
    check("R4 old data on falling edge w8", b, exp8);
    busRead(O_CTRL, a, b);
    check("R4 busy low after window", (a | b) & BUSY, 32'h0);
    busRead(O_DATA, a, b);
    exp32 = want32(20); exp8 = want8(20);
    check("R4 new data w32", a, exp32);
    check("R4 new data w8", b, exp8);

    // R2/R5 latch during busy is blocked, read keeps running
    busWrite(O_CTRL, EN | ASET | 32'd33);
    busWrite(O_CTRL, EN | START | 32'd33);
    curAddr = 33;
    busWrite(O_CTRL, EN | ASET | 32'd44);
    busWrite(O_CTRL, EN | 32'd44);
    repeat (RD_LAT) @(posedge clk);
    @(negedge clk);
    busRead(O_DATA, a, b);
    exp32 = want32(33); exp8 = want8(33);
    check("R2 data from pre-busy pointer w32", a, exp32);
    check("R2 data from pre-busy pointer w8", b, exp8);
    runRead(44, 1'b0, "frozen44");

    // R6 start with power-down set, then with enable clear
    ignoredStart(PD | EN | START | 32'd5, "pd1");
    ignoredStart(START | 32'd6, "en0");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int addr;
      bit doLatch;
      doLatch = ($urandom_range(0, 3) != 0);
      addr = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2047))
                                         : int'($urandom_range(0, 600));
      if ($urandom_range(0, 4) == 0) begin
        if ($urandom_range(0, 1) == 0)
          ignoredStart(PD | EN | START | 32'(addr), "rand pd1");
        else
          ignoredStart(START | 32'(addr), "rand en0");
      end
      runRead(addr, doLatch, "rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule